// File: doc/BRIEF.md
# Array Self-Refresh Request Scheduler

This block decides when a 512-page non-volatile array should rewrite itself to restore charge, and performs that rewrite once the system agrees. Straight after reset it pulls its active-low request output low. If the system never answers, the request is dropped after a programmable number of timebase ticks, and the block then waits a much longer programmable period before asking again. A periodic request stays low until it is answered. Answering is optional: leaving a request unanswered does no harm.

The system answers by pulling the active-low acknowledge low while the request is low. The block then raises the request, raises a busy output that holds off external writes, and visits every page in ascending order. For each page it pulses a one-cycle rewrite strobe with the page index. It then waits for a one-cycle done pulse from the array before it moves on. When the last page reports done, busy falls and the long period starts again from zero. Time is measured only in ticks of an external timebase, so simulation can use short counts.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, `rfsh_req_n` is 0, `wr_block` is 0 and `page_rw_stb` is 0.
- R2: If no acknowledge is taken, the power-up request returns high on the clock edge that samples the EXPIRE_TICKS-th tick. The timer then starts counting the period from zero.
- R3: With no request and no refresh running, `rfsh_req_n` goes low on the edge that samples the PERIOD_TICKS-th tick. It then stays low, with no time limit, until an acknowledge is taken.
- R4: If `rfsh_ack_n` is 0 on an edge while `rfsh_req_n` is 0, then from that edge `rfsh_req_n` is 1, `wr_block` is 1, and `page_rw_stb` is 1 with `page_idx` equal to 0. This holds for both the power-up request and a periodic request.
- R5: An acknowledge is ignored when no request is pending, both while idle and while a refresh is running. The outputs keep following R3 and R6.
- R6: Each page gets exactly one one-cycle strobe. The next page's strobe comes on the edge after the edge that samples `page_done` for the current page. A `page_done` pulse that arrives while no page is being waited on has no effect.
- R7: Pages are visited in the order 0, 1, … PAGES-1. `page_idx` holds its value between strobes. `wr_block` falls on the edge that samples `page_done` for page PAGES-1.
- R8: The period counter restarts when a refresh completes. The next request comes on the edge that samples the PERIOD_TICKS-th tick after `wr_block` falls.
- R9: `wr_block` is 1 from the acknowledge edge until the final done, and `rfsh_req_n` is never 0 while `wr_block` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tick | input | 1 | One-cycle timebase pulse |
| rfsh_ack_n | input | 1 | Active-low acknowledge of a pending request |
| page_done | input | 1 | One-cycle pulse: the array finished rewriting the current page |
| rfsh_req_n | output | 1 | Active-low refresh request |
| wr_block | output | 1 | High while a refresh walk is running; holds off external writes |
| page_idx | output | $clog2(PAGES) | Page being rewritten |
| page_rw_stb | output | 1 | One-cycle strobe: read back and rewrite page `page_idx` |

## Verification
Every output comes straight from a register, so each result is due exactly one edge after the input that causes it. This applies to the request dropping and the strobe for page 0 after an acknowledge edge, to the next strobe after a done pulse, to busy falling after the last done, and to the request after the final counted tick. The bench changes its inputs on falling edges and samples the outputs on the next falling edge, half a cycle after the edge that should have acted. A behavioural model updated on each rising edge predicts all four outputs, and they are compared on every cycle. Directed checks on top of this confirm the exact expiry tick, the period tick, and the page order.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [1:0] {
        SCH_PWRUP_REQ = 2'd0,
        SCH_IDLE      = 2'd1,
        SCH_PERIOD_REQ = 2'd2,
        SCH_WALK      = 2'd3
    } sched_e;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ISSUE = 2'd1,
        WK_WAIT  = 2'd2
    } walk_e;

    function automatic logic requesting(input sched_e s);
        return (s == SCH_PWRUP_REQ) || (s == SCH_PERIOD_REQ);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer
    import refresh_pkg::*;
#(
    parameter int EXPIRE_TICKS = 20,
    parameter int PERIOD_TICKS = 2592000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic clear_i,
    input  logic short_i,
    output logic hit_o
);
    localparam int CW = $clog2(max_int(EXPIRE_TICKS, PERIOD_TICKS) + 1);
    localparam logic [CW-1:0] EXP_LAST = CW'(EXPIRE_TICKS - 1);
    localparam logic [CW-1:0] PER_LAST = CW'(PERIOD_TICKS - 1);

    logic [CW-1:0] count;
    logic [CW-1:0] last;

    assign last  = short_i ? EXP_LAST : PER_LAST;
    assign hit_o = tick_i && !clear_i && (count == last);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            count <= '0;
        end else if (tick_i) begin
            count <= hit_o ? '0 : count + 1'b1;
        end
    end

    // R2 / R3: the count never passes the longer of the two limits
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= ((EXP_LAST > PER_LAST) ? EXP_LAST : PER_LAST));

    // R2: in the short window the count never passes the expiry limit
    a_r2_short_bound: assert property (@(posedge clk) disable iff (rst)
        (short_i && !clear_i) |-> (count <= EXP_LAST));

endmodule

// File: rtl/refresh_walker.sv
module refresh_walker
    import refresh_pkg::*;
#(
    parameter int PAGES = 512
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     done_i,
    output logic [$clog2(PAGES)-1:0] page_o,
    output logic                     strobe_o,
    output logic                     finish_o
);
    localparam int PW = $clog2(PAGES);
    localparam logic [PW-1:0] LAST_PAGE = PW'(PAGES - 1);

    walk_e         wstate;
    logic [PW-1:0] page;

    assign page_o   = page;
    assign strobe_o = (wstate == WK_ISSUE);
    assign finish_o = (wstate == WK_WAIT) && done_i && (page == LAST_PAGE);

    always_ff @(posedge clk) begin
        if (rst) begin
            wstate <= WK_IDLE;
            page   <= '0;
        end else begin
            unique case (wstate)
                WK_IDLE: begin
                    if (start_i) begin
                        wstate <= WK_ISSUE;
                        page   <= '0;
                    end
                end
                WK_ISSUE: wstate <= WK_WAIT;
                WK_WAIT: begin
                    if (done_i) begin
                        if (page == LAST_PAGE) begin
                            wstate <= WK_IDLE;
                        end else begin
                            page   <= page + 1'b1;
                            wstate <= WK_ISSUE;
                        end
                    end
                end
                default: wstate <= WK_IDLE;
            endcase
        end
    end

    // R6: a strobe lasts one cycle only
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);

    // R7: page index holds while waiting for the array
    a_r7_page_hold: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> $stable(page_o));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int PAGES        = 512,
    parameter int EXPIRE_TICKS = 20,
    parameter int PERIOD_TICKS = 2592000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic                     rfsh_ack_n,
    input  logic                     page_done,
    output logic                     rfsh_req_n,
    output logic                     wr_block,
    output logic [$clog2(PAGES)-1:0] page_idx,
    output logic                     page_rw_stb
);
    sched_e state, state_nx;
    logic   take_ack;
    logic   timer_hit;
    logic   timer_clear;
    logic   walk_finish;

    assign take_ack    = requesting(state) && !rfsh_ack_n;
    assign timer_clear = take_ack || (state == SCH_PERIOD_REQ) || (state == SCH_WALK);
    assign rfsh_req_n  = !requesting(state);
    assign wr_block    = (state == SCH_WALK);

    refresh_timer #(
        .EXPIRE_TICKS(EXPIRE_TICKS),
        .PERIOD_TICKS(PERIOD_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .clear_i(timer_clear),
        .short_i(state == SCH_PWRUP_REQ),
        .hit_o  (timer_hit)
    );

    refresh_walker #(
        .PAGES(PAGES)
    ) u_walker (
        .clk     (clk),
        .rst     (rst),
        .start_i (take_ack),
        .done_i  (page_done),
        .page_o  (page_idx),
        .strobe_o(page_rw_stb),
        .finish_o(walk_finish)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            SCH_PWRUP_REQ: begin
                if (take_ack)       state_nx = SCH_WALK;
                else if (timer_hit) state_nx = SCH_IDLE;
            end
            SCH_IDLE:       if (timer_hit)   state_nx = SCH_PERIOD_REQ;
            SCH_PERIOD_REQ: if (take_ack)    state_nx = SCH_WALK;
            SCH_WALK:       if (walk_finish) state_nx = SCH_IDLE;
            default:        state_nx = SCH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SCH_PWRUP_REQ;
        else     state <= state_nx;
    end

    // R4: an acknowledge of a pending request drops it and starts the walk
    a_r4_ack_starts: assert property (@(posedge clk) disable iff (rst)
        (!rfsh_req_n && !rfsh_ack_n) |=> (rfsh_req_n && wr_block && page_rw_stb));

    // R9: never request while a walk is running
    a_r9_no_req_busy: assert property (@(posedge clk) disable iff (rst)
        wr_block |-> rfsh_req_n);

    // R6: strobes only occur inside a walk
    a_r6_stb_in_walk: assert property (@(posedge clk) disable iff (rst)
        page_rw_stb |-> wr_block);

    // R5: an acknowledge without a pending request changes nothing
    a_r5_ack_ignored: assert property (@(posedge clk) disable iff (rst)
        (rfsh_req_n && !wr_block && !rfsh_ack_n) |=> !wr_block);

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int PAGES  = 16;
    localparam int EXPIRE = 5;
    localparam int PERIOD = 12;
    localparam int PW = $clog2(PAGES);

    logic clk = 0;
    logic rst = 1;
    logic tick = 0;
    logic rfsh_ack_n = 1;
    logic page_done = 0;
    logic rfsh_req_n;
    logic wr_block;
    logic [PW-1:0] page_idx;
    logic page_rw_stb;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    refresh_sched #(.PAGES(PAGES), .EXPIRE_TICKS(EXPIRE), .PERIOD_TICKS(PERIOD)) uut (
        .clk(clk), .rst(rst), .tick(tick), .rfsh_ack_n(rfsh_ack_n),
        .page_done(page_done), .rfsh_req_n(rfsh_req_n), .wr_block(wr_block),
        .page_idx(page_idx), .page_rw_stb(page_rw_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: mode 0 power-up request, 1 idle, 2 periodic request, 3 walking
    int m_mode = 0, m_cnt = 0, m_page = 0, m_phase = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_page = 0; m_phase = 0;
        end else begin
            case (m_mode)
                0, 2: begin
                    if (!rfsh_ack_n) begin
                        m_mode = 3; m_phase = 0; m_page = 0; m_cnt = 0;
                    end else if (m_mode == 0 && tick) begin
                        m_cnt++;
                        if (m_cnt == EXPIRE) begin m_mode = 1; m_cnt = 0; end
                    end
                end
                1: if (tick) begin
                    m_cnt++;
                    if (m_cnt == PERIOD) begin m_mode = 2; m_cnt = 0; end
                end
                default: begin
                    if (m_phase == 0) m_phase = 1;
                    else if (page_done) begin
                        if (m_page == PAGES - 1) begin m_mode = 1; m_cnt = 0; end
                        else begin m_page++; m_phase = 0; end
                    end
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R3", "req_n model", int'(rfsh_req_n), (m_mode == 0 || m_mode == 2) ? 0 : 1);
            chk("R9", "busy model", int'(wr_block), (m_mode == 3) ? 1 : 0);
            chk("R6", "strobe model", int'(page_rw_stb), (m_mode == 3 && m_phase == 0) ? 1 : 0);
            chk("R7", "page model", int'(page_idx), m_page);
        end
    end

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1;
            @(negedge clk) tick = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1;
        repeat (3) @(negedge clk);
        chk("R1", "req_n in reset", int'(rfsh_req_n), 0);
        rst = 0;
        @(negedge clk);
        chk("R1", "req_n after reset", int'(rfsh_req_n), 0);
        chk("R1", "busy after reset", int'(wr_block), 0);
        chk("R1", "strobe after reset", int'(page_rw_stb), 0);
    endtask

    task automatic ack_pulse();
        rfsh_ack_n = 0;
        @(negedge clk) rfsh_ack_n = 1;
        chk("R4", "req dropped", int'(rfsh_req_n), 1);
        chk("R4", "busy raised", int'(wr_block), 1);
        chk("R4", "first strobe", int'(page_rw_stb), 1);
        chk("R4", "first page", int'(page_idx), 0);
    endtask

    task automatic walk(input bit noise);
        for (int p = 0; p < PAGES; p++) begin
            int guard = 0;
            while (!page_rw_stb && guard < 20) begin @(negedge clk); guard++; end
            chk("R7", "page order", int'(page_idx), p);
            for (int d = 0; d < 1 + (p % 3); d++) begin
                if (noise && p == 3 && d == 0) rfsh_ack_n = 0; // R5: ack during walk
                @(negedge clk);
                rfsh_ack_n = 1;
                chk("R6", "no repeat strobe", int'(page_rw_stb), 0);
            end
            page_done = 1;
            @(negedge clk) page_done = 0;
            if (p == PAGES - 1) chk("R7", "busy falls after last", int'(wr_block), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R2: power-up request expires after EXPIRE ticks
        give_ticks(EXPIRE - 1);
        chk("R2", "req before expiry", int'(rfsh_req_n), 0);
        give_ticks(1);
        chk("R2", "req after expiry", int'(rfsh_req_n), 1);
        // R5: ack with nothing pending, and a stray done (R6)
        rfsh_ack_n = 0;
        page_done = 1;
        repeat (3) @(negedge clk);
        rfsh_ack_n = 1;
        page_done = 0;
        @(negedge clk);
        chk("R5", "ack idle busy", int'(wr_block), 0);
        chk("R5", "ack idle req", int'(rfsh_req_n), 1);
        // R3: periodic request
        give_ticks(PERIOD - 1);
        chk("R3", "req before period", int'(rfsh_req_n), 1);
        give_ticks(1);
        chk("R3", "req at period", int'(rfsh_req_n), 0);
        give_ticks(2 * PERIOD);
        chk("R3", "periodic req held", int'(rfsh_req_n), 0);
        ack_pulse();
        walk(1'b1);
        // R8: period restarts at completion
        give_ticks(PERIOD - 1);
        chk("R8", "req before restart period", int'(rfsh_req_n), 1);
        give_ticks(1);
        chk("R8", "req after restart period", int'(rfsh_req_n), 0);
        // R4 from power-up request
        do_reset();
        ack_pulse();
        walk(1'b0);
        chk("R9", "idle after walk", int'(wr_block), 0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule